// File: doc/BRIEF.md
# Colour-Ratio Pixel Binarizer with Temporal Frame Mask

This block turns a stream of 4-bit RGB pixels into one foreground bit per pixel. A pixel is foreground when its chosen target colour lies inside a programmable brightness window and is not outweighed by either of the other two colours. The weights can be set so that a comparison colour has to stay well below the target. The resulting binary image then goes through one of four temporal stages. Each stage uses an external 1-bit-per-pixel frame memory: pass-through, motion between consecutive frames, removal of a stored background, or a window grown from the previous frame's result.

The block generates the frame-memory addresses itself. The first valid pixel of a frame is marked with `sof_i`, and each later valid pixel takes the next linear address in row-major order. Configuration inputs are sampled together with each pixel, so they may change between frames without disturbing pixels already in flight. The memory is read with one cycle of latency. The block issues every write the chosen mode needs. In self-window mode it also grows the kept pixels by one column on each side within the row before storing them.

Top module: `color_binarizer_top`

## Requirements
- R1: The target select code picks the colours. Code 0 targets red and compares against green (first) and blue (second). Code 1 targets green against red and blue. Code 2 targets blue against red and green. Code 3 makes every pixel background.
- R2: A pixel can be foreground only if `thr_min_i` <= target value <= `thr_max_i`, with both bounds inclusive.
- R3: With weights unsigned and holding 2 fractional bits, a pixel must satisfy (4 + `wgt1_i`) x first comparison value <= 4 x target value, and the same with `wgt2_i` and the second comparison value. Equality passes.
- R4: A pixel sampled with `pix_valid_i` high at clock edge n appears on `valid_o`/`bin_o` after edge n+2. In the same cycle as the pixel, `fm_rd_en_o` is high and `fm_rd_addr_o` carries its address. That address is 0 for a pixel with `sof_i` high and rises by one for each following valid pixel.
- R5: Mode code 0 (pass) outputs the binarized bit. Mode code 1 (frame difference) outputs the binarized bit XOR the memory bit, and writes the binarized bit back to that pixel's address.
- R6: Mode code 2 (background removal) outputs the binarized bit AND NOT the memory bit. In modes 0 and 2, the memory receives the binarized bits only during a frame whose first pixel arrived with `capture_i` high.
- R7: Mode code 3 (self window) outputs the binarized bit AND the memory bit. For each pixel, the memory receives the OR of the kept outputs of that pixel and its left and right neighbours in the same row. That write is issued when the next pixel leaves the pipeline, and only if that next pixel is also in mode 3.
- R8: During reset `valid_o` and `fm_we_o` are low.
- R9: A cycle with `pix_valid_i` low issues no read and produces no output, and the address sequence resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel present this cycle |
| sof_i | input | 1 | First pixel of a frame |
| pix_r_i | input | 4 | Red value |
| pix_g_i | input | 4 | Green value |
| pix_b_i | input | 4 | Blue value |
| tgt_sel_i | input | 2 | Target colour code |
| thr_min_i | input | 4 | Lower window bound |
| thr_max_i | input | 4 | Upper window bound |
| wgt1_i | input | 4 | Weight for first comparison colour, 2 fractional bits |
| wgt2_i | input | 4 | Weight for second comparison colour, 2 fractional bits |
| mode_i | input | 2 | Temporal mode code |
| capture_i | input | 1 | Store this frame (sampled at frame start) |
| fm_rd_en_o | output | 1 | Frame memory read enable |
| fm_rd_addr_o | output | 5 | Frame memory read address |
| fm_rd_data_i | input | 1 | Frame memory read data, one cycle after the read |
| fm_we_o | output | 1 | Frame memory write enable |
| fm_wr_addr_o | output | 5 | Frame memory write address |
| fm_wr_data_o | output | 1 | Frame memory write data |
| valid_o | output | 1 | Output pixel valid |
| bin_o | output | 1 | Filtered foreground bit |

## Verification
The bench uses the defaults: 4-bit pixels, 4-bit weights with 2 fractional bits, and an 8 x 4 frame. A 32-pixel frame lets a short run cover many complete frames, so every mode sees both a fresh memory and one written by the preceding frame. A row edge occurs every eighth pixel, which exercises the clipping of the self-window growth many times per frame. The frame wrap repeatedly crosses the deferred last-pixel write, including the case where the mode changes at that boundary. Small weights and thresholds also put exact ratio equalities and window bounds within reach of hand-picked pixels.

// File: rtl/binz_pkg.sv
package binz_pkg;
  typedef enum logic [1:0] {
    TGT_RED   = 2'd0,
    TGT_GREEN = 2'd1,
    TGT_BLUE  = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    TM_PASS  = 2'd0,
    TM_FDIFF = 2'd1,
    TM_BGSUB = 2'd2,
    TM_SWIN  = 2'd3
  } tmode_e;
endpackage

// File: rtl/binz_color_test.sv
module binz_color_test
  import binz_pkg::*;
#(
  parameter int PIX_W    = 4,
  parameter int WGT_W    = 4,
  parameter int WGT_FRAC = 2
) (
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  input  logic [1:0]       tgt_sel_i,
  input  logic [PIX_W-1:0] thr_min_i,
  input  logic [PIX_W-1:0] thr_max_i,
  input  logic [WGT_W-1:0] wgt1_i,
  input  logic [WGT_W-1:0] wgt2_i,
  output logic             fg_o
);
  localparam int PW    = PIX_W + WGT_W + 2;
  localparam int SCALE = 1 << WGT_FRAC;

  logic [PIX_W-1:0]            tgt_v;
  logic [1:0][PIX_W-1:0]       cmp_v;
  logic [1:0][WGT_W-1:0]       wgt_v;
  logic                        sel_ok;
  logic [1:0]                  ratio_ok;
  logic [PW-1:0]               rhs;
  logic                        in_win;

  always_comb begin
    sel_ok   = 1'b1;
    tgt_v    = r_i;
    cmp_v[0] = g_i;
    cmp_v[1] = b_i;
    case (tgt_e'(tgt_sel_i))
      TGT_RED:   begin tgt_v = r_i; cmp_v[0] = g_i; cmp_v[1] = b_i; end
      TGT_GREEN: begin tgt_v = g_i; cmp_v[0] = r_i; cmp_v[1] = b_i; end
      TGT_BLUE:  begin tgt_v = b_i; cmp_v[0] = r_i; cmp_v[1] = g_i; end
      default:   sel_ok = 1'b0;
    endcase
  end

  assign wgt_v[0] = wgt1_i;
  assign wgt_v[1] = wgt2_i;
  assign rhs      = PW'(tgt_v) << WGT_FRAC;
  assign in_win   = (tgt_v >= thr_min_i) && (tgt_v <= thr_max_i);

  // weighted comparison colour must not exceed the scaled target
  for (genvar i = 0; i < 2; i++) begin : g_ratio
    logic [PW-1:0] lhs;
    assign lhs         = (PW'(SCALE) + PW'(wgt_v[i])) * PW'(cmp_v[i]);
    assign ratio_ok[i] = (lhs <= rhs);
  end

  assign fg_o = sel_ok & in_win & (&ratio_ok);
endmodule

// File: rtl/binz_addr_gen.sv
module binz_addr_gen #(
  parameter int IMG_W = 8,
  parameter int IMG_H = 4,
  localparam int FRAME_PIX = IMG_W * IMG_H,
  localparam int AW = (FRAME_PIX > 1) ? $clog2(FRAME_PIX) : 1,
  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic          capture_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] col_o,
  output logic          cap_o
);
  logic [AW-1:0] cnt_q;
  logic [CW-1:0] col_q;
  logic          cap_q;

  assign addr_o = sof_i ? '0 : cnt_q;
  assign col_o  = sof_i ? '0 : col_q;
  assign cap_o  = sof_i ? capture_i : cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      col_q <= '0;
      cap_q <= 1'b0;
    end else if (valid_i) begin
      cnt_q <= (addr_o == AW'(FRAME_PIX - 1)) ? '0 : addr_o + 1'b1;
      col_q <= (col_o == CW'(IMG_W - 1)) ? '0 : col_o + 1'b1;
      if (sof_i) cap_q <= capture_i;
    end
  end

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i && $past(valid_i) && ($past(addr_o) != AW'(FRAME_PIX - 1)))
      |-> (addr_o == $past(addr_o) + 1'b1));
endmodule

// File: rtl/binz_temporal.sv
module binz_temporal
  import binz_pkg::*;
#(
  parameter int AW = 5,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          v1_i,
  input  logic          cur_i,
  input  tmode_e        mode1_i,
  input  logic          cap1_i,
  input  logic [AW-1:0] addr1_i,
  input  logic [CW-1:0] col1_i,
  input  logic          rd_data_i,
  output logic          valid_o,
  output logic          bin_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          wdata_o
);
  logic          res;
  logic          v_q, out_q, cur_q, cap_q, h1_q, h2_q, prev_sw_q;
  tmode_e        mode_q;
  logic [AW-1:0] addr_q, addr_p;
  logic [CW-1:0] col_q, col_p;

  always_comb begin
    case (mode1_i)
      TM_FDIFF: res = cur_i ^ rd_data_i;
      TM_BGSUB: res = cur_i & ~rd_data_i;
      TM_SWIN:  res = cur_i & rd_data_i;
      default:  res = cur_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q       <= 1'b0;
      out_q     <= 1'b0;
      cur_q     <= 1'b0;
      cap_q     <= 1'b0;
      h1_q      <= 1'b0;
      h2_q      <= 1'b0;
      prev_sw_q <= 1'b0;
      mode_q    <= TM_PASS;
      addr_q    <= '0;
      addr_p    <= '0;
      col_q     <= '0;
      col_p     <= '0;
    end else begin
      v_q <= v1_i;
      if (v1_i) begin
        out_q     <= res;
        cur_q     <= cur_i;
        cap_q     <= cap1_i;
        mode_q    <= mode1_i;
        addr_q    <= addr1_i;
        col_q     <= col1_i;
        addr_p    <= addr_q;
        col_p     <= col_q;
        h1_q      <= out_q;
        h2_q      <= h1_q;
        prev_sw_q <= (mode_q == TM_SWIN);
      end
    end
  end

  // self window: the previous pixel is written once its right neighbour is known
  always_comb begin
    we_o    = 1'b0;
    waddr_o = addr_q;
    wdata_o = cur_q;
    if (v_q) begin
      case (mode_q)
        TM_FDIFF: we_o = 1'b1;
        TM_SWIN: begin
          we_o    = prev_sw_q;
          waddr_o = addr_p;
          wdata_o = h1_q | ((col_p != '0) & h2_q) | ((col_q != '0) & out_q);
        end
        default:  we_o = cap_q;
      endcase
    end
  end

  assign valid_o = v_q;
  assign bin_o   = out_q;

  assert_bg_removed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && out_q && mode_q == TM_BGSUB) |-> !$past(rd_data_i));

  assert_sw_inside_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && out_q && mode_q == TM_SWIN) |-> $past(rd_data_i));

  assert_fd_rewrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && mode_q == TM_FDIFF) |-> (we_o && waddr_o == addr_q));
endmodule

// File: rtl/color_binarizer_top.sv
module color_binarizer_top
  import binz_pkg::*;
#(
  parameter int PIX_W    = 4,
  parameter int WGT_W    = 4,
  parameter int WGT_FRAC = 2,
  parameter int IMG_W    = 8,
  parameter int IMG_H    = 4,
  localparam int FRAME_PIX = IMG_W * IMG_H,
  localparam int AW = (FRAME_PIX > 1) ? $clog2(FRAME_PIX) : 1,
  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic             sof_i,
  input  logic [PIX_W-1:0] pix_r_i,
  input  logic [PIX_W-1:0] pix_g_i,
  input  logic [PIX_W-1:0] pix_b_i,
  input  logic [1:0]       tgt_sel_i,
  input  logic [PIX_W-1:0] thr_min_i,
  input  logic [PIX_W-1:0] thr_max_i,
  input  logic [WGT_W-1:0] wgt1_i,
  input  logic [WGT_W-1:0] wgt2_i,
  input  logic [1:0]       mode_i,
  input  logic             capture_i,
  output logic             fm_rd_en_o,
  output logic [AW-1:0]    fm_rd_addr_o,
  input  logic             fm_rd_data_i,
  output logic             fm_we_o,
  output logic [AW-1:0]    fm_wr_addr_o,
  output logic             fm_wr_data_o,
  output logic             valid_o,
  output logic             bin_o
);
  logic          fg;
  logic [AW-1:0] addr0;
  logic [CW-1:0] col0;
  logic          cap0;

  logic          v1_q, fg1_q, cap1_q;
  tmode_e        mode1_q;
  logic [AW-1:0] addr1_q;
  logic [CW-1:0] col1_q;

  binz_color_test #(
    .PIX_W(PIX_W), .WGT_W(WGT_W), .WGT_FRAC(WGT_FRAC)
  ) u_color (
    .r_i(pix_r_i), .g_i(pix_g_i), .b_i(pix_b_i),
    .tgt_sel_i(tgt_sel_i), .thr_min_i(thr_min_i), .thr_max_i(thr_max_i),
    .wgt1_i(wgt1_i), .wgt2_i(wgt2_i), .fg_o(fg)
  );

  binz_addr_gen #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(pix_valid_i), .sof_i(sof_i),
    .capture_i(capture_i), .addr_o(addr0), .col_o(col0), .cap_o(cap0)
  );

  assign fm_rd_en_o   = pix_valid_i;
  assign fm_rd_addr_o = addr0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      fg1_q   <= 1'b0;
      cap1_q  <= 1'b0;
      mode1_q <= TM_PASS;
      addr1_q <= '0;
      col1_q  <= '0;
    end else begin
      v1_q <= pix_valid_i;
      if (pix_valid_i) begin
        fg1_q   <= fg;
        cap1_q  <= cap0;
        mode1_q <= tmode_e'(mode_i);
        addr1_q <= addr0;
        col1_q  <= col0;
      end
    end
  end

  binz_temporal #(.AW(AW), .CW(CW)) u_temporal (
    .clk_i(clk_i), .rst_ni(rst_ni), .v1_i(v1_q), .cur_i(fg1_q),
    .mode1_i(mode1_q), .cap1_i(cap1_q), .addr1_i(addr1_q), .col1_i(col1_q),
    .rd_data_i(fm_rd_data_i), .valid_o(valid_o), .bin_o(bin_o),
    .we_o(fm_we_o), .waddr_o(fm_wr_addr_o), .wdata_o(fm_wr_data_o)
  );

  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(pix_valid_i, 2));

  assert_none_target_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && tgt_sel_i == 2'd3 && mode_i == 2'd0) |=> ##1 (valid_o && !bin_o));
endmodule

// File: tb/color_binarizer_top_tb.sv
module color_binarizer_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int H = 4;
  localparam int N = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0, sof = 1'b0, capture = 1'b0;
  logic [3:0] pr = '0, pg = '0, pb = '0, tmin = '0, tmax = '0, w1 = '0, w2 = '0;
  logic [1:0] tsel = '0, mode = '0;
  logic fm_rd_en, fm_rd_data, fm_we, fm_wr_data, valid_o, bin_o;
  logic [4:0] fm_rd_addr, fm_wr_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  color_binarizer_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .sof_i(sof),
    .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb), .tgt_sel_i(tsel),
    .thr_min_i(tmin), .thr_max_i(tmax), .wgt1_i(w1), .wgt2_i(w2),
    .mode_i(mode), .capture_i(capture), .fm_rd_en_o(fm_rd_en),
    .fm_rd_addr_o(fm_rd_addr), .fm_rd_data_i(fm_rd_data), .fm_we_o(fm_we),
    .fm_wr_addr_o(fm_wr_addr), .fm_wr_data_o(fm_wr_data),
    .valid_o(valid_o), .bin_o(bin_o)
  );

  // external 1-bit frame memory, synchronous read
  logic ram [N];
  always @(posedge clk) begin
    if (fm_rd_en) fm_rd_data <= ram[fm_rd_addr];
    if (fm_we) ram[fm_wr_addr] <= fm_wr_data;
  end

  int checks = 0, fails = 0;
  int unsigned seed = 32'h1234_5678;
  bit ref_mem [N];
  bit pend_v = 1'b0, pend_val = 1'b0;
  logic [3:0] img_r [N], img_g [N], img_b [N];
  bit p1_v = 0, p1_b = 0, p2_v = 0, p2_b = 0;
  string p1_req = "R4", p2_req = "R4";

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_test();
  end

  function automatic bit ref_fg(int r, int g, int b, int ts, int lo, int hi, int a1, int a2);
    int t, c1, c2;
    case (ts)
      0: begin t = r; c1 = g; c2 = b; end
      1: begin t = g; c1 = r; c2 = b; end
      2: begin t = b; c1 = r; c2 = g; end
      default: return 1'b0;
    endcase
    return (t >= lo) && (t <= hi) && ((4 + a1) * c1 <= 4 * t) && ((4 + a2) * c2 <= 4 * t);
  endfunction

  function automatic int nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  task automatic fill_random();
    for (int k = 0; k < N; k++) begin
      img_r[k] = 4'(nxt());
      img_g[k] = 4'(nxt() >> 1);
      img_b[k] = 4'(nxt() >> 2);
    end
  endtask

  // boundary cases for target red, window 5..10, w1=2 (1.5x), w2=1 (1.25x)
  task automatic fill_directed();
    for (int k = 0; k < N; k++) begin
      case (k % 8)
        0: begin img_r[k] = 5;  img_g[k] = 0; img_b[k] = 0; end
        1: begin img_r[k] = 4;  img_g[k] = 0; img_b[k] = 0; end
        2: begin img_r[k] = 10; img_g[k] = 0; img_b[k] = 0; end
        3: begin img_r[k] = 11; img_g[k] = 0; img_b[k] = 0; end
        4: begin img_r[k] = 6;  img_g[k] = 4; img_b[k] = 0; end
        5: begin img_r[k] = 5;  img_g[k] = 4; img_b[k] = 0; end
        6: begin img_r[k] = 5;  img_g[k] = 0; img_b[k] = 4; end
        default: begin img_r[k] = 5; img_g[k] = 0; img_b[k] = 5; end
      endcase
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(valid_o === p2_v, "R4", int'(valid_o), int'(p2_v));
    if (p2_v) check(bin_o === p2_b, p2_req, int'(bin_o), int'(p2_b));
    p2_v = p1_v; p2_b = p1_b; p2_req = p1_req;
    p1_v = 0;
  endtask

  task automatic idle();
    step();
    pix_valid = 0; sof = 0;
    #1 check(fm_rd_en === 1'b0, "R9", int'(fm_rd_en), 0);
  endtask

  task automatic run_frame(int md, int ts, int lo, int hi, int a1, int a2, bit cap);
    bit c [N];
    bit o [N];
    string req;
    if (pend_v && md == 3) ref_mem[N-1] = pend_val;
    pend_v = 0;
    case (md)
      0: req = (ts == 3) ? "R1" : "R3";
      1: req = "R5";
      2: req = "R6";
      default: req = "R7";
    endcase
    for (int k = 0; k < N; k++) begin
      c[k] = ref_fg(img_r[k], img_g[k], img_b[k], ts, lo, hi, a1, a2);
      case (md)
        1: o[k] = c[k] ^ ref_mem[k];
        2: o[k] = c[k] & ~ref_mem[k];
        3: o[k] = c[k] & ref_mem[k];
        default: o[k] = c[k];
      endcase
    end
    for (int k = 0; k < N; k++) begin
      if (k == 13) idle();
      step();
      pix_valid = 1; sof = (k == 0); capture = cap;
      pr = img_r[k]; pg = img_g[k]; pb = img_b[k];
      tsel = 2'(ts); tmin = 4'(lo); tmax = 4'(hi); w1 = 4'(a1); w2 = 4'(a2);
      mode = 2'(md);
      p1_v = 1; p1_b = o[k]; p1_req = req;
      #1 check(fm_rd_en === 1'b1 && fm_rd_addr === 5'(k), "R4", int'(fm_rd_addr), k);
    end
    idle();
    idle();
    case (md)
      1: for (int k = 0; k < N; k++) ref_mem[k] = c[k];
      3: begin
        for (int k = 0; k < N; k++) begin
          int col = k % W;
          bit wv = o[k] | ((col > 0) && o[k-1]) | ((col < W - 1) && o[k+1]);
          if (k < N - 1) ref_mem[k] = wv;
          else begin pend_v = 1; pend_val = wv; end
        end
      end
      default: if (cap) for (int k = 0; k < N; k++) ref_mem[k] = c[k];
    endcase
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin ram[k] = 1'b0; ref_mem[k] = 1'b0; end
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0, "R8", int'(valid_o), 0);
    check(fm_we === 1'b0, "R8", int'(fm_we), 0);
    rst_n = 1'b1;
    idle();
    // R1 R2 R3: colour routing, window and ratio in pass mode
    fill_random(); run_frame(0, 0, 3, 15, 1, 1, 0);
    fill_random(); run_frame(0, 1, 2, 14, 0, 2, 0);
    fill_random(); run_frame(0, 2, 1, 13, 3, 0, 0);
    fill_random(); run_frame(0, 3, 0, 15, 0, 0, 0);
    fill_directed(); run_frame(0, 0, 5, 10, 2, 1, 0);
    // R5: frame difference
    fill_random(); run_frame(1, 0, 2, 15, 0, 0, 0);
    fill_random(); run_frame(1, 0, 2, 15, 0, 0, 0);
    fill_random(); run_frame(1, 1, 1, 15, 0, 1, 0);
    // R6: background capture then removal
    fill_random(); run_frame(0, 0, 2, 15, 0, 0, 1);
    fill_random(); run_frame(2, 0, 2, 15, 0, 0, 0);
    fill_random(); run_frame(2, 0, 2, 15, 0, 0, 0);
    fill_random(); run_frame(2, 0, 2, 15, 0, 0, 1);
    fill_random(); run_frame(2, 0, 2, 15, 0, 0, 0);
    // R7: self window seeded by a captured frame
    fill_random(); run_frame(0, 0, 1, 15, 0, 0, 1);
    fill_random(); run_frame(3, 0, 1, 15, 0, 0, 0);
    fill_random(); run_frame(3, 0, 0, 15, 0, 0, 0);
    fill_random(); run_frame(3, 0, 0, 15, 0, 0, 0);
    // R7: leaving self window drops the pending last write
    fill_random(); run_frame(0, 0, 2, 15, 0, 0, 0);
    fill_random(); run_frame(1, 0, 2, 15, 0, 0, 0);
    idle(); idle();
    finish_test();
  end
endmodule